// File: doc/BRIEF.md
# Steerable Serial Configuration Cell

This block is the loader for one cell of a tiled array. Configuration bits reach the cell one at a time on a serial data line, and a shift strobe marks each valid bit. Each cell starts by reading a short header from the stream. The header says whether the cell wants a configuration word, whether it ends the chain, and which of its four neighbours gets the stream after it. A cell that wants a word shifts the next 28 bits into its configuration register. After that it relays every further bit to the chosen neighbour. A cell that does not want a word relays the stream as soon as its header is complete. The result is a chain that threads only through the cells that need loading.

A selected cell that ends the chain raises its done flag when its register is full. From then on it ignores the stream, so shifting stops across the whole chain. Relayed bits leave through one data/strobe pair per neighbour and are registered once inside the cell. Each cell therefore adds one clock of latency to the stream.

Top module: `cfg_route_cell`

## Requirements
- R1: While `rst` is high at a clock edge, the cell clears `cfg` to zero, clears `filled` and `done`, and drives all eight neighbour outputs low after that edge.
- R2: The first four strobed bits after reset form the header, taken in this order: select, end-of-chain, direction MSB, direction LSB. No neighbour output strobes while the header is loading.
- R3: In a selected cell, the 28 strobed bits after the header shift into `cfg` MSB first, so the first payload bit ends in `cfg[27]`. No bit is relayed while the register is filling.
- R4: `filled` is low until the edge that captures the 28th payload bit and is high after that edge.
- R5: A filled, selected cell that does not end the chain relays each later strobed bit. The cell drives the chosen neighbour's strobe high for one cycle, one clock after the input strobe, with the data bit on that neighbour's data line. `cfg` does not change.
- R6: The direction code selects the neighbour: 00 north, 01 east, 10 south, 11 west. The data and strobe outputs of the other three neighbours stay low. A relayed data line is high only while its strobe is high and the relayed bit is 1.
- R7: An unselected cell relays every strobed bit that follows its header. Its `cfg` stays zero and `filled` stays low. Its end-of-chain bit has no effect.
- R8: A selected cell that ends the chain raises `done` at the same edge as `filled`. After that it ignores all strobes, relays nothing and holds `cfg` until reset.
- R9: Changes on `sin` while `sstb` is low have no effect on `cfg`, on the bit count or on the outputs.
- R10: A reset in the middle of a stream discards the partial word, and the next strobed bit is read as the first header bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sin | input | 1 | Serial data in |
| sstb | input | 1 | Shift strobe; a high cycle carries one bit |
| n_dat | output | 1 | Relayed data toward north |
| n_stb | output | 1 | Relayed strobe toward north |
| e_dat | output | 1 | Relayed data toward east |
| e_stb | output | 1 | Relayed strobe toward east |
| s_dat | output | 1 | Relayed data toward south |
| s_stb | output | 1 | Relayed strobe toward south |
| w_dat | output | 1 | Relayed data toward west |
| w_stb | output | 1 | Relayed strobe toward west |
| cfg | output | 28 | Configuration word |
| filled | output | 1 | Configuration register holds all its bits |
| done | output | 1 | This cell ended the chain and is full |

## Verification
A bit count that drifts by one shows up at the ports within a single strobe. `filled` rises one payload bit early or late, and the first relayed strobe appears on a bit where none is expected. A misread header field shows up at the first relayed bit, either as a strobe on the wrong neighbour or as a missing stop after the final cell. The bench checks the outputs after every strobe, so any such fault is reported on the strobe where it first occurs.

// File: rtl/cfg_route_cell.sv
module cfg_route_cell #(
  parameter int CFG_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sin,
  input  logic             sstb,
  output logic             n_dat,
  output logic             n_stb,
  output logic             e_dat,
  output logic             e_stb,
  output logic             s_dat,
  output logic             s_stb,
  output logic             w_dat,
  output logic             w_stb,
  output logic [CFG_W-1:0] cfg,
  output logic             filled,
  output logic             done
);
  localparam int HW = 4;
  localparam int HCW = $clog2(HW + 1);
  localparam int CW = $clog2(CFG_W + 1);

  logic [HCW-1:0] hcnt;
  logic [HW-1:0]  hdr;
  logic [CW-1:0]  pcnt;
  logic           fstb, fdat;
  logic [3:0]     hot;

  wire hdr_ok = (hcnt == HCW'(HW));
  wire sel    = hdr[3];
  wire lst    = hdr[2];
  wire take   = sstb && hdr_ok && sel && !filled;
  wire pass   = sstb && hdr_ok && !done && (!sel || filled);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt   <= '0;
      hdr    <= '0;
      pcnt   <= '0;
      cfg    <= '0;
      filled <= 1'b0;
      done   <= 1'b0;
      fstb   <= 1'b0;
      fdat   <= 1'b0;
    end else begin
      if (sstb && !hdr_ok) begin
        hdr  <= {hdr[HW-2:0], sin};
        hcnt <= hcnt + HCW'(1);
      end
      if (take) begin
        cfg  <= {cfg[CFG_W-2:0], sin};
        pcnt <= pcnt + CW'(1);
        if (pcnt == CW'(CFG_W - 1)) begin
          filled <= 1'b1;
          done   <= lst;
        end
      end
      fstb <= pass;
      fdat <= pass & sin;
    end
  end

  assign hot   = 4'b0001 << hdr[1:0];
  assign n_stb = fstb & hot[0];
  assign e_stb = fstb & hot[1];
  assign s_stb = fstb & hot[2];
  assign w_stb = fstb & hot[3];
  assign n_dat = fdat & hot[0];
  assign e_dat = fdat & hot[1];
  assign s_dat = fdat & hot[2];
  assign w_dat = fdat & hot[3];
endmodule

// File: rtl/cfg_route_cell_chk.sv
module cfg_route_cell_chk #(
  parameter int CFG_W = 28
) (
  input logic             clk,
  input logic             rst,
  input logic             sin,
  input logic             sstb,
  input logic             n_dat,
  input logic             n_stb,
  input logic             e_dat,
  input logic             e_stb,
  input logic             s_dat,
  input logic             s_stb,
  input logic             w_dat,
  input logic             w_stb,
  input logic [CFG_W-1:0] cfg,
  input logic             filled,
  input logic             done
);
  wire [3:0] stbs = {w_stb, s_stb, e_stb, n_stb};
  wire [3:0] dats = {w_dat, s_dat, e_dat, n_dat};

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cfg == '0 && !filled && !done && stbs == 4'b0 && dats == 4'b0));

  a_r6_one_neighbour: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stbs));

  a_r6_data_with_strobe: assert property (@(posedge clk) disable iff (rst)
    (dats & ~stbs) == 4'b0);

  a_r4_filled_sticky: assert property (@(posedge clk) disable iff (rst)
    (filled && !rst) |=> filled);

  a_r8_done_freezes: assert property (@(posedge clk) disable iff (rst)
    (done && !rst) |=> ($stable(cfg) && stbs == 4'b0));

  a_r8_done_needs_filled: assert property (@(posedge clk) disable iff (rst)
    done |-> filled);

  a_r9_idle_holds_cfg: assert property (@(posedge clk) disable iff (rst)
    (!sstb && !rst) |=> $stable(cfg));

  a_r5_relay_follows_strobe: assert property (@(posedge clk) disable iff (rst)
    (!sstb && !rst) |=> stbs == 4'b0);
endmodule

bind cfg_route_cell cfg_route_cell_chk #(.CFG_W(CFG_W)) u_chk (.*);

// File: tb/test_cfg_route_cell.sv
module test_cfg_route_cell;
  logic        clk = 1'b0;
  logic        rst, sin, sstb;
  logic        n_dat, n_stb, e_dat, e_stb, s_dat, s_stb, w_dat, w_stb;
  logic [27:0] cfg;
  logic        filled, done;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cfg_route_cell i_cfg_route_cell (
    .clk(clk), .rst(rst), .sin(sin), .sstb(sstb),
    .n_dat(n_dat), .n_stb(n_stb), .e_dat(e_dat), .e_stb(e_stb),
    .s_dat(s_dat), .s_stb(s_stb), .w_dat(w_dat), .w_stb(w_stb),
    .cfg(cfg), .filled(filled), .done(done));

  // {header[3:0], payload[27:0], expected cfg[27:0], expected neighbour {W,S,E,N}}
  localparam logic [63:0] VEC [7] = '{
    {4'b1000, 28'hA5C3F0E, 28'hA5C3F0E, 4'b0001},
    {4'b1001, 28'h1234567, 28'h1234567, 4'b0010},
    {4'b1010, 28'hFFFFFFF, 28'hFFFFFFF, 4'b0100},
    {4'b1011, 28'h8000001, 28'h8000001, 4'b1000},
    {4'b0001, 28'h5A5A5A5, 28'h0000000, 4'b0010},
    {4'b1110, 28'h0F0F0F1, 28'h0F0F0F1, 4'b0100},
    {4'b0111, 28'hC000003, 28'h0000000, 4'b1000}
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    sin = b;
    sstb = 1'b1;
    @(negedge clk);
    sstb = 1'b0;
    sin = 1'b0;
  endtask

  task automatic check_out(input logic [3:0] mask, input logic b, input string req);
    logic [7:0] act, exp;
    act = {w_stb, s_stb, e_stb, n_stb, w_dat, s_dat, e_dat, n_dat};
    exp = {mask, b ? mask : 4'b0};
    check(act == exp, req, {24'b0, act}, {24'b0, exp});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; sin = 1'b0; sstb = 1'b0;
    repeat (3) @(negedge clk);
    check(cfg == 28'h0 && !filled && !done, "R1 reset state", {4'b0, cfg}, 32'h0);
    check_out(4'b0, 1'b0, "R1 outputs low in reset");
    rst = 1'b0;

    for (int i = 0; i < 7; i++) begin
      logic [3:0]  hd;
      logic [27:0] pl, ecfg;
      logic [3:0]  mk;
      logic        sl, ls;
      {hd, pl, ecfg, mk} = VEC[i];
      sl = hd[3];
      ls = hd[2];
      do_reset();
      for (int h = 3; h >= 0; h--) begin
        pulse(hd[h]);
        check_out(4'b0, 1'b0, "R2 no relay during header");
      end
      for (int p = 27; p >= 0; p--) begin
        pulse(pl[p]);
        if (sl) begin
          check_out(4'b0, 1'b0, "R3 no relay while filling");
          check(filled == (p == 0), "R4 filled timing", {31'b0, filled}, {31'b0, p == 0});
        end else begin
          check_out(mk, pl[p], "R7 unselected relays after header");
          check(!filled, "R7 unselected never filled", {31'b0, filled}, 32'h0);
        end
      end
      check(cfg == ecfg, sl ? "R3 cfg loaded MSB first" : "R7 unselected cfg stays zero", {4'b0, cfg}, {4'b0, ecfg});
      check(done == (sl && ls), "R8 done on last selected cell", {31'b0, done}, {31'b0, sl && ls});
      pulse(1'b1); check_out((sl && ls) ? 4'b0 : mk, 1'b1, "R5 R6 relay to decoded neighbour");
      pulse(1'b0); check_out((sl && ls) ? 4'b0 : mk, 1'b0, "R5 R6 relay zero bit");
      pulse(1'b1); check_out((sl && ls) ? 4'b0 : mk, 1'b1, "R6 R8 relay or stop");
      @(negedge clk);
      check_out(4'b0, 1'b0, "R5 relayed strobe lasts one cycle");
      check(cfg == ecfg, "R5 R8 cfg held after full", {4'b0, cfg}, {4'b0, ecfg});
    end

    // R9: sin toggling without strobe has no effect
    do_reset();
    pulse(1'b1); pulse(1'b0); pulse(1'b0); pulse(1'b1);
    for (int k = 0; k < 5; k++) begin
      sin = k[0];
      @(negedge clk);
      check_out(4'b0, 1'b0, "R9 no relay without strobe");
    end
    sin = 1'b0;
    check(cfg == 28'h0, "R9 cfg unchanged without strobe", {4'b0, cfg}, 32'h0);
    for (int p = 0; p < 27; p++) pulse(1'b0);
    check(!filled, "R9 count unaffected, not yet filled", {31'b0, filled}, 32'h0);
    pulse(1'b0);
    check(filled, "R9 filled on 28th strobe", {31'b0, filled}, 32'h1);
    pulse(1'b1);
    check_out(4'b0010, 1'b1, "R9 relay east after fill");

    // R10: reset mid-stream restarts at the header
    do_reset();
    pulse(1'b1); pulse(1'b1); pulse(1'b0); pulse(1'b0);
    for (int p = 0; p < 10; p++) pulse(1'b1);
    check(cfg == 28'h00003FF, "R10 partial word before reset", {4'b0, cfg}, 32'h3FF);
    do_reset();
    check(cfg == 28'h0 && !filled && !done, "R10 partial word discarded", {4'b0, cfg}, 32'h0);
    pulse(1'b0); pulse(1'b0); pulse(1'b1); pulse(1'b0);
    check_out(4'b0, 1'b0, "R10 new header loads quietly");
    pulse(1'b1);
    check_out(4'b0100, 1'b1, "R10 new header routes south");
    check(cfg == 28'h0, "R10 unselected after restart", {4'b0, cfg}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule